// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block counts frame events for both directions of an Ethernet MAC. Once per frame in each direction, the datapath reports the frame length in bytes, the destination class, a VLAN-tag flag and a pause-frame flag. It also reports error flags: a single error flag for transmit, and FCS, alignment, in-range length, too-long and drop flags for receive. From each report the block updates its counters. These cover good and errored frames, octets, the unicast, multicast and broadcast split, VLAN and pause frames, and RMON-style receive length bins. They also cover undersize, oversize, fragment and jabber frames.

Every counter is `CNT_W` bits wide, 64 by default, and wraps. Software reads it over a read port `RD_W` bits wide, 32 by default, as two words. The upper word sits at the even word address and the lower word at the odd address that follows. Reading the upper word also captures the lower word. The next lower-word read therefore returns half of the same snapshot, even if frames keep arriving between the two reads.

Top module: `frame_stat_bank`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears every counter to zero and drops `rd_valid`.
- R2: Counter k is read at word address 2k (upper half) and 2k+1 (lower half). `rd_valid` and `rd_data` appear one clock after `rd_en`. Index map: 0 tx good, 1 tx error, 2 tx octets, 3 tx unicast, 4 tx multicast, 5 tx broadcast, 6 tx VLAN, 7 tx pause, 8 rx good, 9 rx octets, 10 rx unicast, 11 rx multicast, 12 rx broadcast, 13 rx VLAN, 14 rx pause, 15 rx FCS error, 16 rx alignment error, 17 rx length error, 18 rx too long, 19 rx total errors, 20 rx drops, 21 undersize, 22 fragment, 23 oversize, 24 jabber, 25 to 31 the seven length bins in ascending order.
- R3: A transmit report counts as good when the error flag is clear and as an error otherwise. Only good frames add to the class, VLAN and pause counters. The class code is 00 unicast, 01 multicast, 10 broadcast and 11 none.
- R4: Every report adds its length to the octet counter of its direction, whatever its flags.
- R5: Each receive error flag (FCS, alignment, length, too long) increments its own counter. A report with any of these flags set increments the total-errors counter. A report with none of them set increments the good counter.
- R6: A receive report adds to the class, VLAN and pause counters only when it is good, using the same class code as R3.
- R7: A receive frame between 64 and `MAX_LEN` bytes lands in exactly one bin: 64, 65-127, 128-255, 256-511, 512-1023, 1024-1518, or 1519-`MAX_LEN`. The bin does not depend on the error flags.
- R8: A receive frame shorter than 64 bytes counts as undersize when its FCS is good and as a fragment when its FCS is bad. It counts in no bin.
- R9: A receive frame longer than `MAX_LEN` (1536 by default) counts as oversize when its FCS is good and as a jabber when its FCS is bad. It counts in no bin.
- R10: The drop flag increments the drop counter on its own, without affecting the good or error decision.
- R11: An upper-word read captures the lower word of the same counter. The next lower-word read returns that captured value if it addresses the same counter, and the capture is then released. Any other lower-word read returns the live value.
- R12: When a frame report and a read fall in the same cycle, the increment still takes effect, and the read returns the value from before it.
- R13: Counters wrap modulo 2^`CNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_eof | input | 1 | Transmit frame report strobe |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_cls | input | 2 | Transmit destination class code |
| tx_vlan | input | 1 | Transmit frame carries a VLAN tag |
| tx_pause | input | 1 | Transmit frame is a pause frame |
| tx_err | input | 1 | Transmit frame had an error |
| rx_eof | input | 1 | Receive frame report strobe |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_cls | input | 2 | Receive destination class code |
| rx_vlan | input | 1 | Receive frame carries a VLAN tag |
| rx_pause | input | 1 | Receive frame is a pause frame |
| rx_fcs_err | input | 1 | Receive FCS mismatch |
| rx_align_err | input | 1 | Receive alignment error |
| rx_len_err | input | 1 | Receive in-range length error |
| rx_too_long | input | 1 | Receive frame flagged too long by the MAC |
| rx_drop | input | 1 | Receive frame was dropped |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | RD_W | Read data word |

## Verification
A frame report and a register read can fall in the same clock, and they can touch the same counter. The bench provokes this by asserting a good receive report in the cycle that it reads the lower word of the receive good-frame counter. The returned word must equal the bench's count from before that frame, and a second read must show the incremented value. In a related sequence, a frame arrives between an upper-word read and its matching lower-word read. The lower-word read must return the captured value and not the live one. The bench uses 16-bit counters read as 8-bit words, so the octet counters wrap many times during the length sweeps.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

   localparam int NUM_CNT  = 32;
   localparam int NUM_BINS = 7;
   localparam int MIN_LEN  = 64;

   localparam int C_TX_GOOD  = 0;
   localparam int C_TX_ERR   = 1;
   localparam int C_TX_OCT   = 2;
   localparam int C_TX_UC    = 3;
   localparam int C_TX_MC    = 4;
   localparam int C_TX_BC    = 5;
   localparam int C_TX_VLAN  = 6;
   localparam int C_TX_PAUSE = 7;
   localparam int C_RX_GOOD  = 8;
   localparam int C_RX_OCT   = 9;
   localparam int C_RX_UC    = 10;
   localparam int C_RX_MC    = 11;
   localparam int C_RX_BC    = 12;
   localparam int C_RX_VLAN  = 13;
   localparam int C_RX_PAUSE = 14;
   localparam int C_RX_FCS   = 15;
   localparam int C_RX_ALIGN = 16;
   localparam int C_RX_LENE  = 17;
   localparam int C_RX_LONG  = 18;
   localparam int C_RX_ERRS  = 19;
   localparam int C_RX_DROP  = 20;
   localparam int C_RX_UNDER = 21;
   localparam int C_RX_FRAG  = 22;
   localparam int C_RX_OVER  = 23;
   localparam int C_RX_JAB   = 24;
   localparam int C_BIN0     = 25;

   localparam logic [1:0] CLS_UNI   = 2'b00;
   localparam logic [1:0] CLS_MULTI = 2'b01;
   localparam logic [1:0] CLS_BROAD = 2'b10;

   // lower edge of a receive length bin
   function automatic int bin_low(input int b);
      case (b)
         0:       return 64;
         1:       return 65;
         2:       return 128;
         3:       return 256;
         4:       return 512;
         5:       return 1024;
         default: return 1519;
      endcase
   endfunction

   // upper edge of a receive length bin; the top bin ends at the maximum length
   function automatic int bin_high(input int b, input int max_len);
      case (b)
         0:       return 64;
         1:       return 127;
         2:       return 255;
         3:       return 511;
         4:       return 1023;
         5:       return 1518;
         default: return max_len;
      endcase
   endfunction

endpackage

// File: rtl/fstat_counter.sv
module fstat_counter #(
   parameter int CNT_W = 64,
   parameter int AMT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [AMT_W-1:0] amt,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc)
         cnt <= cnt + CNT_W'(amt);
   end

   // R1: reset leaves the counter at zero
   a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> cnt == '0);

   // R13: each step adds the amount modulo the counter width
   a_r13_modular_step: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> cnt == $past(cnt) + CNT_W'($past(amt)));

   a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt));

endmodule

// File: rtl/fstat_tx_decode.sv
module fstat_tx_decode
   import fstat_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eof,
   input  logic [1:0]         cls,
   input  logic               vlan,
   input  logic               pause,
   input  logic               err,
   output logic [NUM_CNT-1:0] ev
);

   logic good;

   always_comb begin
      good             = eof && !err;
      ev               = '0;
      ev[C_TX_GOOD]    = good;
      ev[C_TX_ERR]     = eof && err;
      ev[C_TX_OCT]     = eof;
      ev[C_TX_UC]      = good && (cls == CLS_UNI);
      ev[C_TX_MC]      = good && (cls == CLS_MULTI);
      ev[C_TX_BC]      = good && (cls == CLS_BROAD);
      ev[C_TX_VLAN]    = good && vlan;
      ev[C_TX_PAUSE]   = good && pause;
   end

   // R3: a report is either good or errored, never both
   a_r3_good_xor_err: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> $countones({ev[C_TX_GOOD], ev[C_TX_ERR]}) == 1);

   // R3: at most one class counter moves per report
   a_r3_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev[C_TX_UC], ev[C_TX_MC], ev[C_TX_BC]}));

endmodule

// File: rtl/fstat_rx_decode.sv
module fstat_rx_decode
   import fstat_pkg::*;
#(
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1536
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eof,
   input  logic [LEN_W-1:0]   len,
   input  logic [1:0]         cls,
   input  logic               vlan,
   input  logic               pause,
   input  logic               fcs_err,
   input  logic               align_err,
   input  logic               len_err,
   input  logic               too_long,
   input  logic               drop,
   output logic [NUM_CNT-1:0] ev
);

   localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] LONG_LIM  = LEN_W'(MAX_LEN);

   logic                any_err, good, is_short, is_long;
   logic [NUM_BINS-1:0] bin_hit;

   assign is_short = len < SHORT_LIM;
   assign is_long  = len > LONG_LIM;

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      localparam logic [LEN_W-1:0] LO = LEN_W'(bin_low(b));
      localparam logic [LEN_W-1:0] HI = LEN_W'(bin_high(b, MAX_LEN));
      assign bin_hit[b] = eof && (len >= LO) && (len <= HI);
   end

   always_comb begin
      any_err        = fcs_err || align_err || len_err || too_long;
      good           = eof && !any_err;
      ev             = '0;
      ev[C_RX_GOOD]  = good;
      ev[C_RX_OCT]   = eof;
      ev[C_RX_UC]    = good && (cls == CLS_UNI);
      ev[C_RX_MC]    = good && (cls == CLS_MULTI);
      ev[C_RX_BC]    = good && (cls == CLS_BROAD);
      ev[C_RX_VLAN]  = good && vlan;
      ev[C_RX_PAUSE] = good && pause;
      ev[C_RX_FCS]   = eof && fcs_err;
      ev[C_RX_ALIGN] = eof && align_err;
      ev[C_RX_LENE]  = eof && len_err;
      ev[C_RX_LONG]  = eof && too_long;
      ev[C_RX_ERRS]  = eof && any_err;
      ev[C_RX_DROP]  = eof && drop;
      ev[C_RX_UNDER] = eof && is_short && !fcs_err;
      ev[C_RX_FRAG]  = eof && is_short && fcs_err;
      ev[C_RX_OVER]  = eof && is_long && !fcs_err;
      ev[C_RX_JAB]   = eof && is_long && fcs_err;
      for (int b = 0; b < NUM_BINS; b++)
         ev[C_BIN0+b] = bin_hit[b];
   end

   // R7 R8 R9: every report lands in exactly one size class
   a_r7_one_size_class: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> $countones({bin_hit, ev[C_RX_UNDER], ev[C_RX_FRAG],
                          ev[C_RX_OVER], ev[C_RX_JAB]}) == 1);

   // R8: short frames never reach a bin
   a_r8_short_no_bin: assert property (@(posedge clk) disable iff (!rst_n)
      (eof && is_short) |-> bin_hit == '0);

   // R5: an FCS error excludes the good count
   a_r5_fcs_not_good: assert property (@(posedge clk) disable iff (!rst_n)
      (eof && fcs_err) |-> !ev[C_RX_GOOD] && ev[C_RX_ERRS]);

endmodule

// File: rtl/fstat_read_port.sv
module fstat_read_port
   import fstat_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int RD_W   = 32,
   parameter int ADDR_W = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
   input  logic                            rd_en,
   input  logic [ADDR_W-1:0]               rd_addr,
   output logic                            rd_valid,
   output logic [RD_W-1:0]                 rd_data
);

   localparam int IDX_W = ADDR_W - 1;

   logic [IDX_W-1:0] idx, snap_idx;
   logic             is_upper, snap_vld, snap_hit;
   logic [RD_W-1:0]  snap_lo, live_hi, live_lo;

   always_comb begin
      idx      = rd_addr[ADDR_W-1:1];
      is_upper = !rd_addr[0];
      live_hi  = cnt[idx][CNT_W-1:RD_W];
      live_lo  = cnt[idx][RD_W-1:0];
      snap_hit = snap_vld && (snap_idx == idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         snap_lo  <= '0;
         snap_idx <= '0;
         snap_vld <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            if (is_upper) begin
               rd_data  <= live_hi;
               snap_lo  <= live_lo;
               snap_idx <= idx;
               snap_vld <= 1'b1;
            end else begin
               rd_data  <= snap_hit ? snap_lo : live_lo;
               snap_vld <= 1'b0;
            end
         end
      end
   end

   // R2: data is valid exactly one cycle after the request
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R11: an upper read arms the capture, a lower read releases it
   a_r11_capture_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && is_upper) |=> snap_vld && snap_idx == $past(idx));

   a_r11_capture_released: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !is_upper) |=> !snap_vld);

endmodule

// File: rtl/frame_stat_bank.sv
module frame_stat_bank
   import fstat_pkg::*;
#(
   parameter int CNT_W   = 64,
   parameter int RD_W    = 32,
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1536,
   localparam int ADDR_W = $clog2(NUM_CNT) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_eof,
   input  logic [LEN_W-1:0]  tx_len,
   input  logic [1:0]        tx_cls,
   input  logic              tx_vlan,
   input  logic              tx_pause,
   input  logic              tx_err,
   input  logic              rx_eof,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic [1:0]        rx_cls,
   input  logic              rx_vlan,
   input  logic              rx_pause,
   input  logic              rx_fcs_err,
   input  logic              rx_align_err,
   input  logic              rx_len_err,
   input  logic              rx_too_long,
   input  logic              rx_drop,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [RD_W-1:0]   rd_data
);

   if (CNT_W != 2 * RD_W) begin : g_bad_split
      $error("CNT_W must be twice RD_W");
   end
   if (MAX_LEN < 1519) begin : g_bad_max
      $error("MAX_LEN must cover the 1519 byte bin edge");
   end
   if (MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for MAX_LEN");
   end

   logic [NUM_CNT-1:0]            tx_ev, rx_ev, inc;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;

   fstat_tx_decode i_tx_decode (
      .clk   (clk),
      .rst_n (rst_n),
      .eof   (tx_eof),
      .cls   (tx_cls),
      .vlan  (tx_vlan),
      .pause (tx_pause),
      .err   (tx_err),
      .ev    (tx_ev)
   );

   fstat_rx_decode #(
      .LEN_W   (LEN_W),
      .MAX_LEN (MAX_LEN)
   ) i_rx_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .eof       (rx_eof),
      .len       (rx_len),
      .cls       (rx_cls),
      .vlan      (rx_vlan),
      .pause     (rx_pause),
      .fcs_err   (rx_fcs_err),
      .align_err (rx_align_err),
      .len_err   (rx_len_err),
      .too_long  (rx_too_long),
      .drop      (rx_drop),
      .ev        (rx_ev)
   );

   assign inc = tx_ev | rx_ev;

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic [LEN_W-1:0] amt;
      if (k == C_TX_OCT) begin : g_tx_oct
         assign amt = tx_len;
      end else if (k == C_RX_OCT) begin : g_rx_oct
         assign amt = rx_len;
      end else begin : g_unit
         assign amt = LEN_W'(1);
      end
      fstat_counter #(
         .CNT_W (CNT_W),
         .AMT_W (LEN_W)
      ) i_counter (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc[k]),
         .amt   (amt),
         .cnt   (cnt_all[k])
      );
   end

   fstat_read_port #(
      .CNT_W  (CNT_W),
      .RD_W   (RD_W),
      .ADDR_W (ADDR_W)
   ) i_read_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt_all),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   // R3 R6: the two decoders never claim the same counter
   a_r6_disjoint_events: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ev & rx_ev) == '0);

   // R1: no read data is flagged straight out of reset
   a_r1_valid_low: assert property (@(posedge clk) !rst_n |=> !rd_valid);

endmodule

// File: tb/test_frame_stat_bank.sv
module test_frame_stat_bank;

   localparam int CW = 16;
   localparam int RW = 8;
   localparam int LW = 11;
   localparam int ML = 1536;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_eof = 0, tx_vlan = 0, tx_pause = 0, tx_err = 0;
   logic [LW-1:0] tx_len = '0;
   logic [1:0]    tx_cls = '0;
   logic          rx_eof = 0, rx_vlan = 0, rx_pause = 0, rx_fcs_err = 0;
   logic          rx_align_err = 0, rx_len_err = 0, rx_too_long = 0, rx_drop = 0;
   logic [LW-1:0] rx_len = '0;
   logic [1:0]    rx_cls = '0;
   logic          rd_en = 0;
   logic [5:0]    rd_addr = '0;
   logic          rd_valid;
   logic [RW-1:0] rd_data;

   int            nchk = 0;
   int            nerr = 0;
   logic [CW-1:0] exp_c [32];

   always #10 clk = ~clk;

   frame_stat_bank #(
      .CNT_W (CW), .RD_W (RW), .LEN_W (LW), .MAX_LEN (ML)
   ) i_frame_stat_bank (
      .clk (clk), .rst_n (rst_n),
      .tx_eof (tx_eof), .tx_len (tx_len), .tx_cls (tx_cls),
      .tx_vlan (tx_vlan), .tx_pause (tx_pause), .tx_err (tx_err),
      .rx_eof (rx_eof), .rx_len (rx_len), .rx_cls (rx_cls),
      .rx_vlan (rx_vlan), .rx_pause (rx_pause), .rx_fcs_err (rx_fcs_err),
      .rx_align_err (rx_align_err), .rx_len_err (rx_len_err),
      .rx_too_long (rx_too_long), .rx_drop (rx_drop),
      .rd_en (rd_en), .rd_addr (rd_addr), .rd_valid (rd_valid), .rd_data (rd_data)
   );

   task automatic chk(input string req, input int act, input int expv);
      nchk++;
      if (act !== expv) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic string req_of(input int k);
      if (k == 2 || k == 9) return "R4 R13";
      if (k < 8)            return "R3";
      if (k <= 14 && k != 8) return "R6";
      if (k <= 19)          return "R5";
      if (k == 20)          return "R10";
      if (k <= 22)          return "R8";
      if (k <= 24)          return "R9";
      return "R7";
   endfunction

   task automatic rd_word(input int addr, output logic [RW-1:0] d);
      @(negedge clk);
      rd_en   = 1'b1;
      rd_addr = 6'(addr);
      @(negedge clk);
      rd_en = 1'b0;
      d     = rd_data;
      chk("R2 valid", int'(rd_valid), 1);
   endtask

   task automatic model_tx(input int len, input int cls, input bit v, input bit p, input bit e);
      exp_c[2] = exp_c[2] + CW'(len);
      if (e) exp_c[1]++;
      else begin
         exp_c[0]++;
         if (cls < 3) exp_c[3+cls]++;
         if (v) exp_c[6]++;
         if (p) exp_c[7]++;
      end
   endtask

   task automatic model_rx(input int len, input int cls, input bit v, input bit p,
                           input bit f, input bit a, input bit l, input bit t, input bit d);
      bit any;
      any = f | a | l | t;
      exp_c[9] = exp_c[9] + CW'(len);
      if (!any) begin
         exp_c[8]++;
         if (cls < 3) exp_c[10+cls]++;
         if (v) exp_c[13]++;
         if (p) exp_c[14]++;
      end else exp_c[19]++;
      if (f) exp_c[15]++;
      if (a) exp_c[16]++;
      if (l) exp_c[17]++;
      if (t) exp_c[18]++;
      if (d) exp_c[20]++;
      if (len < 64)        exp_c[f ? 22 : 21]++;
      else if (len > ML)   exp_c[f ? 24 : 23]++;
      else if (len == 64)  exp_c[25]++;
      else if (len <= 127) exp_c[26]++;
      else if (len <= 255) exp_c[27]++;
      else if (len <= 511) exp_c[28]++;
      else if (len <= 1023) exp_c[29]++;
      else if (len <= 1518) exp_c[30]++;
      else                 exp_c[31]++;
   endtask

   task automatic drive_rx(input int len, input int cls, input bit v, input bit p,
                           input bit f, input bit a, input bit l, input bit t, input bit d);
      rx_eof = 1'b1; rx_len = LW'(len); rx_cls = 2'(cls); rx_vlan = v; rx_pause = p;
      rx_fcs_err = f; rx_align_err = a; rx_len_err = l; rx_too_long = t; rx_drop = d;
   endtask

   task automatic send(input bit do_tx, input int tl, input int tc, input bit tv,
                       input bit tp, input bit te, input bit do_rx, input int rl,
                       input int rc, input bit rv, input bit rp, input bit f,
                       input bit a, input bit l, input bit t, input bit d);
      @(negedge clk);
      if (do_tx) begin
         tx_eof = 1'b1; tx_len = LW'(tl); tx_cls = 2'(tc);
         tx_vlan = tv; tx_pause = tp; tx_err = te;
         model_tx(tl, tc, tv, tp, te);
      end
      if (do_rx) begin
         drive_rx(rl, rc, rv, rp, f, a, l, t, d);
         model_rx(rl, rc, rv, rp, f, a, l, t, d);
      end
      @(negedge clk);
      tx_eof = 1'b0;
      rx_eof = 1'b0;
   endtask

   task automatic dump_all();
      logic [RW-1:0] d;
      for (int k = 0; k < 32; k++) begin
         rd_word(2*k, d);
         chk({req_of(k), " upper"}, int'(d), int'(exp_c[k][CW-1:RW]));
         rd_word(2*k+1, d);
         chk({req_of(k), " lower"}, int'(d), int'(exp_c[k][RW-1:0]));
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL R1 watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [RW-1:0] d;
      logic [RW-1:0] old_lo;
      int bl[15] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024,
                     1518, 1519, 1536, 1537};
      for (int k = 0; k < 32; k++) exp_c[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: counters and valid cleared
      chk("R1 rd_valid", int'(rd_valid), 0);
      dump_all();

      // sweep of lengths and flag mixes in both directions (R3-R10, R13)
      for (int i = 0; i < 223; i++) begin
         send(1'b1, 64 + (i * 13) % 1480, i % 4, (i % 2) == 1, (i % 6) == 0, (i % 5) == 2,
              1'b1, 40 + 7 * i, (i + 1) % 4, (i % 3) == 1, (i % 4) == 0,
              (i % 5) == 0, (i % 7) == 0, (i % 11) == 0, (i % 13) == 0, (i % 3) == 0);
      end
      dump_all();

      // bin and size-class edges with good and bad FCS (R7 R8 R9)
      for (int j = 0; j < 15; j++) begin
         for (int f = 0; f < 2; f++) begin
            send(1'b0, 0, 0, 0, 0, 0, 1'b1, bl[j], 0, 0, 0, f[0], 0, 0, 0, 0);
         end
      end
      dump_all();

      // R11: capture survives a frame between upper and lower reads
      rd_word(18, d);
      chk("R11 upper", int'(d), int'(exp_c[9][CW-1:RW]));
      old_lo = exp_c[9][RW-1:0];
      send(1'b0, 0, 0, 0, 0, 0, 1'b1, 100, 0, 0, 0, 0, 0, 0, 0, 0);
      rd_word(19, d);
      chk("R11 captured lower", int'(d), int'(old_lo));
      rd_word(19, d);
      chk("R11 live lower after release", int'(d), int'(exp_c[9][RW-1:0]));
      // R11: lower read of another counter sees its live value
      rd_word(18, d);
      rd_word(17, d);
      chk("R11 other counter live", int'(d), int'(exp_c[8][RW-1:0]));

      // R12: report and read of the same counter in one cycle
      old_lo = exp_c[8][RW-1:0];
      @(negedge clk);
      drive_rx(80, 0, 0, 0, 0, 0, 0, 0, 0);
      rd_en   = 1'b1;
      rd_addr = 6'd17;
      @(negedge clk);
      rx_eof = 1'b0;
      rd_en  = 1'b0;
      chk("R12 pre-increment value", int'(rd_data), int'(old_lo));
      model_rx(80, 0, 0, 0, 0, 0, 0, 0, 0);
      rd_word(17, d);
      chk("R12 increment applied", int'(d), int'(exp_c[8][RW-1:0]));

      // R1: reset in mid-run clears everything again
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 32; k++) exp_c[k] = '0;
      dump_all();

      finish_run();
   end

endmodule